// File: doc/BRIEF.md
# Alternating-Polarity Ripple-Carry Adder–Subtractor

This block is a purely combinational N-bit binary adder. It is built as a chain of one-bit full-adder cells whose carry output gate is inverting. Even-numbered stages take operands and carry in true form and hand on an inverted carry. Odd-numbered stages take complemented operands together with that inverted carry. A full adder is self-dual, so an odd stage hands back a true carry. The carry therefore crosses every stage boundary with no inverter on the chain. Inverters sit only at the operand and result edges, off the carry path.

A subtract control turns the block into a two's-complement adder–subtractor. The control complements operand B and forces the chain's carry-in to one. A signed overflow flag is produced from the carries into and out of the most significant stage. The carry-merge gate of each cell can be built as an OR or as an XOR. The two forms give the same result, because the gate's two inputs are never high together.

Top module: `arc_adder`

## Requirements
- R1: With `sub_en` = 0, the concatenation {`carry_out`, `sum`} equals `op_a` + `op_b` + `carry_in` as an unsigned WIDTH+1 bit value.
- R2: With `sub_en` = 1, `sum` equals `op_a` − `op_b` modulo 2^WIDTH, and `carry_out` is 1 exactly when `op_a` ≥ `op_b` as unsigned numbers (1 means no borrow).
- R3: `overflow` is 1 exactly when the two's-complement result does not fit in WIDTH bits. In add mode the result is a + b + carry_in; in subtract mode it is a − b. Both operands are read as signed.
- R4: A carry ripples through every stage. For example, all-ones plus zero with `carry_in` = 1 gives `sum` = 0 and `carry_out` = 1, and alternating bit patterns produce correct carries across both even-to-odd and odd-to-even stage boundaries.
- R5: `sum` and `carry_out` are always presented in true polarity, for even and for odd WIDTH (for example 7).
- R6: With `sub_en` = 1, `carry_in` has no effect: both of its values give the same `sum`, `carry_out` and `overflow`.
- R7: The variant whose cells merge the carry terms with XOR (MERGE = MERGE_XOR) gives the same outputs as the R1–R3 definitions for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Operand A (augend or minuend) |
| op_b | input | WIDTH | Operand B (addend or subtrahend) |
| carry_in | input | 1 | Carry into bit 0 in add mode; ignored in subtract mode |
| sub_en | input | 1 | 1 selects A − B, 0 selects A + B + carry_in |
| sum | output | WIDTH | Result, true polarity |
| carry_out | output | 1 | Carry out of the top bit, true polarity |
| overflow | output | 1 | Signed two's-complement overflow |

## Verification
Immediate assertions run whenever the inputs change. They check three things: each cell's two outputs against a bit count of its three inputs, the full-width add and subtract results against arithmetic on the ports, and the overflow flag against the operand and result sign bits. Some properties need two instances or two stimuli to show, so only the bench's scenarios cover them. These are the indifference to `carry_in` in subtract mode, the true-polarity outputs of an odd-width build and the agreement of the XOR-merge variant. The same holds for long carry ripples across every stage boundary.

// File: rtl/arc_pkg.sv
package arc_pkg;

  // Gate used to merge the generate and propagate terms of a cell's carry
  typedef enum logic {
    MERGE_OR  = 1'b0,
    MERGE_XOR = 1'b1
  } carry_merge_e;

  // Odd-numbered stages work on complemented signals
  function automatic logic stage_inverted(input int idx);
    return logic'((idx % 2) == 1);
  endfunction

endpackage

// File: rtl/arc_operand_prep.sv
module arc_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic             sub_en,
  output logic [WIDTH-1:0] a_pol,
  output logic [WIDTH-1:0] b_pol,
  output logic             chain_cin
);

  logic [WIDTH-1:0] lane_inv;
  logic [WIDTH-1:0] b_true;

  // Per-lane polarity mask: set for odd stages
  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign lane_inv[i] = arc_pkg::stage_inverted(i);
  end

  // Two's-complement subtract: complement B, force carry into stage 0
  always_comb begin
    b_true    = op_b ^ {WIDTH{sub_en}};
    chain_cin = sub_en ? 1'b1 : carry_in;
    a_pol     = op_a ^ lane_inv;
    b_pol     = b_true ^ lane_inv;
  end

endmodule

// File: rtl/arc_cell.sv
module arc_cell #(
  parameter arc_pkg::carry_merge_e MERGE = arc_pkg::MERGE_OR
) (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co_n
);

  logic prop;
  logic gen;
  logic pass;

  assign prop = x ^ y;
  assign gen  = x & y;
  assign pass = ci & prop;
  assign s    = prop ^ ci;

  // Inverting carry gate; gen and pass are never both high
  if (MERGE == arc_pkg::MERGE_XOR) begin : g_xor_merge
    assign co_n = ~(gen ^ pass);
  end else begin : g_or_merge
    assign co_n = ~(gen | pass);
  end

  always_comb begin
    assert ({~co_n, s} == (2'(x) + 2'(y) + 2'(ci)))
      else $error("cell outputs disagree with bit count"); // R1
  end

endmodule

// File: rtl/arc_chain.sv
module arc_chain #(
  parameter int                    WIDTH = 32,
  parameter arc_pkg::carry_merge_e MERGE = arc_pkg::MERGE_OR
) (
  input  logic [WIDTH-1:0] a_pol,
  input  logic [WIDTH-1:0] b_pol,
  input  logic             chain_cin,
  output logic [WIDTH-1:0] s_pol,
  output logic             link_msb,
  output logic             link_end
);

  // link[i] is the carry into stage i, inverted when i is odd
  logic [WIDTH:0] link;

  assign link[0] = chain_cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    arc_cell #(.MERGE(MERGE)) u_cell (
      .x    (a_pol[i]),
      .y    (b_pol[i]),
      .ci   (link[i]),
      .s    (s_pol[i]),
      .co_n (link[i+1])
    );
  end

  assign link_msb = link[WIDTH-1];
  assign link_end = link[WIDTH];

endmodule

// File: rtl/arc_result.sv
module arc_result #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] s_pol,
  input  logic             link_msb,
  input  logic             link_end,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             overflow
);

  localparam logic END_INV = arc_pkg::stage_inverted(WIDTH);
  localparam logic MSB_INV = arc_pkg::stage_inverted(WIDTH - 1);

  logic [WIDTH-1:0] lane_inv;
  logic             c_into_msb;

  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign lane_inv[i] = arc_pkg::stage_inverted(i);
  end

  always_comb begin
    sum        = s_pol ^ lane_inv;
    carry_out  = link_end ^ END_INV;
    c_into_msb = link_msb ^ MSB_INV;
    overflow   = c_into_msb ^ carry_out;
  end

endmodule

// File: rtl/arc_adder.sv
module arc_adder #(
  parameter int                    WIDTH = 32,
  parameter arc_pkg::carry_merge_e MERGE = arc_pkg::MERGE_OR
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic             sub_en,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             overflow
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] a_pol;
  logic [WIDTH-1:0] b_pol;
  logic [WIDTH-1:0] s_pol;
  logic             chain_cin;
  logic             link_msb;
  logic             link_end;

  arc_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sub_en    (sub_en),
    .a_pol     (a_pol),
    .b_pol     (b_pol),
    .chain_cin (chain_cin)
  );

  arc_chain #(.WIDTH(WIDTH), .MERGE(MERGE)) u_chain (
    .a_pol     (a_pol),
    .b_pol     (b_pol),
    .chain_cin (chain_cin),
    .s_pol     (s_pol),
    .link_msb  (link_msb),
    .link_end  (link_end)
  );

  arc_result #(.WIDTH(WIDTH)) u_res (
    .s_pol     (s_pol),
    .link_msb  (link_msb),
    .link_end  (link_end),
    .sum       (sum),
    .carry_out (carry_out),
    .overflow  (overflow)
  );

  always_comb begin
    if (!sub_en) begin
      AST_ADD_MATCH: assert ({carry_out, sum} ==
                             ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
        else $error("add result mismatch"); // R1
    end else begin
      AST_SUB_MATCH: assert ((sum == (op_a - op_b)) && (carry_out == (op_a >= op_b)))
        else $error("subtract result mismatch"); // R2
    end
    AST_OVF_SIGNS: assert (overflow ==
                           (((op_a[MSB] == (op_b[MSB] ^ sub_en))) && (sum[MSB] != op_a[MSB])))
      else $error("overflow flag mismatch"); // R3
  end

endmodule

// File: tb/tb_arc_adder.sv
module tb_arc_adder;

  localparam int W  = 32;
  localparam int WO = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  a, b;
  logic [WO-1:0] ao, bo;
  logic          cin, sub;
  logic [W-1:0]  s;
  logic [WO-1:0] so;
  logic          co, ov, coo, ovo;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  arc_adder dut (
    .op_a(a), .op_b(b), .carry_in(cin), .sub_en(sub),
    .sum(s), .carry_out(co), .overflow(ov)
  );

  arc_adder #(.WIDTH(WO), .MERGE(arc_pkg::MERGE_XOR)) dut_odd (
    .op_a(ao), .op_b(bo), .carry_in(cin), .sub_en(sub),
    .sum(so), .carry_out(coo), .overflow(ovo)
  );

  function automatic void model(input int w, input logic [63:0] va, input logic [63:0] vb,
                                input bit vc, input bit vs,
                                output logic [63:0] es, output bit ec, output bit eo);
    logic [63:0] m = (64'd1 << w) - 64'd1;
    logic [63:0] x = va & m;
    logic [63:0] y = vb & m;
    longint half = longint'(64'd1 << (w - 1));
    longint sx, sy, r;
    if (!vs) begin
      logic [63:0] t = x + y + 64'(vc);
      es = t & m;
      ec = t[w];
    end else begin
      es = (x - y) & m;
      ec = (x >= y);
    end
    sx = (longint'(x) >= half) ? longint'(x) - 2 * half : longint'(x);
    sy = (longint'(y) >= half) ? longint'(y) - 2 * half : longint'(y);
    r  = vs ? (sx - sy) : (sx + sy + longint'(vc));
    eo = (r > half - 1) || (r < -half);
  endfunction

  task automatic cmp(input string tag, input logic [63:0] gs, input logic gc, input logic go,
                     input logic [63:0] es, input bit ec, input bit eo);
    checks++;
    if ((gs !== es) || (gc !== ec) || (go !== eo)) begin
      errors++;
      $display("FAIL %s: sum=%h cout=%b ovf=%b expected sum=%h cout=%b ovf=%b",
               tag, gs, gc, go, es, ec, eo);
    end
  endtask

  task automatic apply(input string tag, input logic [63:0] va, input logic [63:0] vb,
                       input bit vc, input bit vs);
    logic [63:0] es;
    bit ec, eo;
    @(posedge clk);
    a   = va[W-1:0];
    b   = vb[W-1:0];
    ao  = va[WO-1:0];
    bo  = vb[WO-1:0];
    cin = vc;
    sub = vs;
    @(negedge clk);
    model(W, va, vb, vc, vs, es, ec, eo);
    cmp(tag, 64'(s), co, ov, es, ec, eo);
    model(WO, va, vb, vc, vs, es, ec, eo);
    cmp({tag, " odd-width R5 xor-merge R7"}, 64'(so), coo, ovo, es, ec, eo);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A1B));
    rst_n = 1'b0;
    a = '0; b = '0; ao = '0; bo = '0; cin = 1'b0; sub = 1'b0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset-time state: zero inputs give zero outputs (R1)
    cmp("R1 reset", 64'(s), co, ov, 64'd0, 1'b0, 1'b0);

    // R1: directed additions
    apply("R1", 64'd0, 64'd0, 1'b0, 1'b0);
    apply("R1", 64'd12345, 64'd54321, 1'b1, 1'b0);
    // R4: full-length ripple and alternating patterns
    apply("R4", 64'hFFFF_FFFF, 64'd0, 1'b1, 1'b0);
    apply("R4", 64'hFFFF_FFFF, 64'd1, 1'b0, 1'b0);
    apply("R4", 64'hAAAA_AAAA, 64'h5555_5555, 1'b1, 1'b0);
    apply("R4", 64'h5555_5555, 64'h5555_5555, 1'b0, 1'b0);
    // R3: signed overflow corners
    apply("R3", 64'h7FFF_FFFF, 64'd1, 1'b0, 1'b0);
    apply("R3", 64'h8000_0000, 64'h8000_0000, 1'b0, 1'b0);
    apply("R3", 64'h7FFF_FFFF, 64'd0, 1'b1, 1'b0);
    apply("R3", 64'h8000_0000, 64'd1, 1'b0, 1'b1);
    apply("R3", 64'h7FFF_FFFF, 64'hFFFF_FFFF, 1'b0, 1'b1);
    // R2: subtract corners
    apply("R2", 64'd0, 64'd1, 1'b0, 1'b1);
    apply("R2", 64'hDEAD_BEEF, 64'hDEAD_BEEF, 1'b0, 1'b1);
    apply("R2", 64'd0, 64'd0, 1'b0, 1'b1);
    // R6: carry_in has no effect while subtracting
    apply("R6", 64'h1234_5678, 64'h0FED_CBA9, 1'b0, 1'b1);
    apply("R6", 64'h1234_5678, 64'h0FED_CBA9, 1'b1, 1'b1);
    apply("R6", 64'd5, 64'd9, 1'b1, 1'b1);

    // Constrained random: mix of small, extreme and full-range operands
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] ra, rb;
      int pick = $urandom_range(0, 3);
      ra = 64'($urandom);
      rb = 64'($urandom);
      if (pick == 0) ra = 64'($urandom_range(0, 15));
      if (pick == 1) rb = 64'hFFFF_FFFF ^ 64'($urandom_range(0, 3));
      if (pick == 2) rb = ra;
      if ($urandom_range(0, 1) == 1)
        apply("R2 R3 random", ra, rb, 1'($urandom), 1'b1);
      else
        apply("R1 R3 random", ra, rb, 1'($urandom), 1'b0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule